// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a register of parameterised width whose next contents are chosen on each rising clock edge by a 2-bit mode code. It can keep its value, move every bit one place toward the least significant end, move every bit one place toward the most significant end, or take a whole parallel word in one edge. Each shift direction has its own serial input, which fills the bit position left empty by the move.

An active-low clear resets every bit to zero at once, without waiting for a clock edge, and it overrides the mode code for as long as it is low. The full register contents are always visible on the output. The block fits where one storage element has to act as a serial-to-parallel converter, a parallel-to-serial converter or a plain holding register, depending on the cycle.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode 2'b00, a rising clock edge leaves the output `q` equal to its value before the edge.
- R2: With mode 2'b01, a rising edge moves every bit one place toward bit 0: bit i takes the old bit i+1, and the most significant bit takes `ser_right_in`.
- R3: With mode 2'b10, a rising edge moves every bit one place toward the top: bit i takes the old bit i-1, and bit 0 takes `ser_left_in`.
- R4: With mode 2'b11, a rising edge copies `par_in` into every bit of `q` at once.
- R5: All bits are stored on the same rising edge of `clk`, and the result of a mode applied before an edge appears on `q` right after that edge, with no further latency.
- R6: Driving `clr_n` low forces `q` to all zeros at once, without waiting for a clock edge.
- R7: While `clr_n` is low, clock edges leave `q` at zero whatever the mode and data inputs are.
- R8: Both serial inputs have no effect in modes 2'b00 and 2'b11, and `par_in` has no effect in modes 2'b00, 2'b01 and 2'b10.
- R9: The width is set by parameter `W` (default 4, at least 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every storage bit, rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift toward bit 0, 10 shift toward the top bit, 11 parallel load |
| ser_right_in | input | 1 | Bit entering at the top during a shift toward bit 0 |
| ser_left_in | input | 1 | Bit entering at bit 0 during a shift toward the top |
| par_in | input | W | Word taken in by a parallel load |
| q | output | W | Register contents |

## Verification
The clocked properties take it for granted that the mode code, the serial inputs and the parallel word are steady around each rising edge, and that the clear is released away from a clock edge. The stimulus changes every input a quarter period after a rising edge and never moves the clear on an edge, so each edge sees settled values. The check that the clear has already forced zero is sampled on the falling edge, which gives an asynchronous clear asserted mid-cycle time to act before it is examined.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

    // One-hot source select for every bit cell.
    typedef struct packed {
        logic keep;      // own old value
        logic from_up;   // neighbour above (or right-serial input)
        logic from_dn;   // neighbour below (or left-serial input)
        logic from_par;  // parallel word
    } sel_t;

    function automatic sel_t decode_mode(mode_e m);
        sel_t s;
        s = '0;
        unique case (m)
            MODE_HOLD: s.keep     = 1'b1;
            MODE_SHR:  s.from_up  = 1'b1;
            MODE_SHL:  s.from_dn  = 1'b1;
            MODE_LOAD: s.from_par = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] mode_i,
    output sel_t       sel_o
);

    always_comb begin
        sel_o = decode_mode(mode_e'(mode_i));
    end

endmodule

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
    import usr_pkg::*;
(
    input  sel_t sel_i,
    input  logic own_i,
    input  logic up_i,
    input  logic dn_i,
    input  logic par_i,
    output logic d_o
);

    always_comb begin
        d_o = (sel_i.keep     & own_i)
            | (sel_i.from_up  & up_i)
            | (sel_i.from_dn  & dn_i)
            | (sel_i.from_par & par_i);
    end

endmodule

// File: rtl/usr_reg_bank.sv
module usr_reg_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   mode,
    input  logic         ser_right_in,
    input  logic         ser_left_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);

    localparam int TOP = W - 1;

    sel_t         sel;
    logic [W-1:0] up_src;
    logic [W-1:0] dn_src;
    logic [W-1:0] d_next;

    usr_mode_decode u_dec (
        .mode_i (mode),
        .sel_o  (sel)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == TOP) begin : g_top
            assign up_src[i] = ser_right_in;
        end else begin : g_mid_up
            assign up_src[i] = q[i+1];
        end

        if (i == 0) begin : g_bot
            assign dn_src[i] = ser_left_in;
        end else begin : g_mid_dn
            assign dn_src[i] = q[i-1];
        end

        usr_bit_cell u_cell (
            .sel_i (sel),
            .own_i (q[i]),
            .up_i  (up_src[i]),
            .dn_i  (dn_src[i]),
            .par_i (par_in[i]),
            .d_o   (d_next[i])
        );
    end

    usr_reg_bank #(.W(W)) u_bank (
        .clk   (clk),
        .clr_n (clr_n),
        .d_i   (d_next),
        .q_o   (q)
    );

endmodule

// File: rtl/usr_shift_chk.sv
module usr_shift_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic [1:0]   mode,
    input logic         ser_right_in,
    input logic         ser_left_in,
    input logic [W-1:0] par_in,
    input logic [W-1:0] q
);

    // R1
    hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b00) |=> (q == $past(q)));

    // R2
    shr_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (q == {$past(ser_right_in), $past(q[W-1:1])}));

    // R3
    shl_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b10) |=> (q == {$past(q[W-2:0]), $past(ser_left_in)}));

    // R4
    load_word_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |=> (q == $past(par_in)));

    // R6
    clr_zero_chk: assert property (@(negedge clk)
        (!clr_n) |-> (q == '0));

    // R7
    clr_prio_chk: assert property (@(posedge clk)
        (!clr_n && !$past(clr_n)) |-> (q == '0));

endmodule

bind usr_shift_reg usr_shift_chk #(.W(W)) u_chk (
    .clk          (clk),
    .clr_n        (clr_n),
    .mode         (mode),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .par_in       (par_in),
    .q            (q)
);

// File: tb/tb_usr_shift_reg.sv
module tb_usr_shift_reg;

    localparam int W  = 4;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         clr_n;
    logic [1:0]   mode = 2'b00;
    logic         ser_right_in = 1'b0;
    logic         ser_left_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    usr_shift_reg #(.W(W)) dut (
        .clk          (clk),
        .clr_n        (clr_n),
        .mode         (mode),
        .ser_right_in (ser_right_in),
        .ser_left_in  (ser_left_in),
        .par_in       (par_in),
        .q            (q)
    );

    // Vector: {mode[1:0], ser_right, ser_left, par[3:0], expected q[3:0]}
    localparam logic [11:0] VEC [NV] = '{
        {2'b11, 1'b0, 1'b0, 4'b1010, 4'b1010},  // R4 load
        {2'b00, 1'b0, 1'b0, 4'b0101, 4'b1010},  // R1 hold, R8 par ignored
        {2'b01, 1'b1, 1'b0, 4'b0000, 4'b1101},  // R2 shift with 1 in
        {2'b01, 1'b0, 1'b1, 4'b1111, 4'b0110},  // R2 shift with 0 in
        {2'b10, 1'b0, 1'b1, 4'b0000, 4'b1101},  // R3 shift with 1 in
        {2'b10, 1'b1, 1'b0, 4'b0000, 4'b1010},  // R3 shift with 0 in
        {2'b11, 1'b1, 1'b1, 4'b0111, 4'b0111},  // R4 load, R8 serial ignored
        {2'b10, 1'b0, 1'b1, 4'b0000, 4'b1111},  // R3
        {2'b01, 1'b0, 1'b0, 4'b0000, 4'b0111},  // R2
        {2'b01, 1'b0, 1'b0, 4'b1000, 4'b0011},  // R2
        {2'b00, 1'b1, 1'b1, 4'b1111, 4'b0011},  // R1, R8 all data ignored
        {2'b10, 1'b1, 1'b0, 4'b1111, 4'b0110}   // R3
    };

    task automatic check(input string req, input logic [W-1:0] exp);
        n_checks++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    // Apply inputs 5 ns after a rising edge, then sample 5 ns after the next.
    task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                        input logic [W-1:0] p);
        mode = m;
        ser_right_in = sr;
        ser_left_in = sl;
        par_in = p;
        @(posedge clk);
        #5;
    endtask

    initial begin
        clr_n = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        check("R6 reset state", '0);
        clr_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
            check($sformatf("R5 vector %0d", i), VEC[i][3:0]);
        end

        // R6: clear mid-cycle acts without a clock edge
        step(2'b11, 1'b0, 1'b0, 4'b1111);
        check("R4 load before clear", 4'b1111);
        #3;
        clr_n = 1'b0;
        #1;
        check("R6 async clear", '0);

        // R7: clear held across edges overrides a load
        mode = 2'b11;
        par_in = 4'b1001;
        @(posedge clk);
        #5;
        check("R7 clear over load", '0);
        mode = 2'b10;
        ser_left_in = 1'b1;
        @(posedge clk);
        #5;
        check("R7 clear over shift", '0);
        clr_n = 1'b1;

        // R3 after release: shift a 1 in from bit 0
        step(2'b10, 1'b0, 1'b1, 4'b0000);
        check("R3 after release", 4'b0001);
        // R2 top fill: ser_right enters bit W-1
        step(2'b01, 1'b1, 1'b0, 4'b0000);
        check("R2 top fill", 4'b1000);
        // R8: par ignored during shift
        step(2'b01, 1'b0, 1'b0, 4'b1111);
        check("R8 par ignored in shift", 4'b0100);
        // R9: top bit of the default width falls out on a left shift
        step(2'b11, 1'b0, 1'b0, 4'b1000);
        step(2'b10, 1'b0, 1'b0, 4'b0000);
        check("R9 bit W-1 drops out", 4'b0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule